// File: doc/BRIEF.md
# Serial Shift Unit with Selectable Clock Source

This block is a general-purpose serial shifter. An 8-bit shift register moves left one place per clock event and takes the synchronized serial input into bit 0. A 4-bit edge counter runs beside it. The clock event comes from one of three places, chosen by a 2-bit select field:

- a software strobe written over the register bus,
- a compare-match pulse from a timer,
- a serial clock. The serial clock is either an external pin or a clock line that software toggles.

The serial output comes from an output latch. Under software or timer clocking the latch is transparent. Under serial-clock clocking it updates only on the clock edge opposite the one that samples the input, so the output changes half a serial period away from the sampling point.

Each counter wrap raises an overflow flag. Software clears the flag by writing one to it. The flag is gated by a local enable and a global enable into an interrupt request. In a serial-clock mode, 16 counted edges make one byte, because the counter advances on both edges.

The register map has three registers:

| Register | Address | Bits |
|---|---|---|
| DATA | 0 | the shift register, read and write |
| STAT | 1 | bit 7 is the overflow flag; bits 3:0 are the counter |
| CTRL | 2 | bit 7 is the overflow interrupt enable; bits 3:2 are the clock select; bit 1 is the strobe or clock option; bit 0 is the toggle strobe |

The clock select values are:

- 00: software strobe
- 01: timer match
- 10: serial clock, sampling on the rising edge
- 11: serial clock, sampling on the falling edge

Top module: `sshift_unit`

## Requirements
- R1: After reset, DATA, STAT and CTRL read 0x00, and irq, sdo and sclk_out are 0.
- R2: With select 00, a CTRL write with bit 1 set shifts DATA left, loads the synchronized sdi_pin into bit 0 and increments the counter, all in the cycle of the write.
- R3: With select 01, each cycle with tmr_match high shifts DATA and increments the counter once. In this mode, a CTRL write with bit 1 set shifts nothing and counts nothing.
- R4: With select 1x and CTRL bit 1 clear, the counter increments on both edges of the synchronized sclk_pin. DATA shifts only on the sampling edge: the rising edge when select bit 2 is 0, the falling edge when it is 1.
- R5: With select 1x, sdo takes the current DATA bit 7 only on the non-sampling edge and holds its value otherwise, including across DATA writes. With select 0x, sdo equals DATA bit 7 from the cycle that DATA changes.
- R6: With select 1x and CTRL bit 1 set, each CTRL write with bit 0 set inverts sclk_out. The sclk_out line then takes the place of sclk_pin as the serial clock, and edges on sclk_pin have no effect.
- R7: When a clock event finds the counter at 15, the counter becomes 0 and the STAT bit 7 flag becomes 1.
- R8: A STAT write with bit 7 set clears the flag. A STAT write with bit 7 clear leaves the flag unchanged. An overflow in the same cycle as a clearing write leaves the flag set.
- R9: irq is high exactly while the flag, CTRL bit 7 and gie are all high. A flag that is already set raises irq in the cycle after the enable is written.
- R10: A STAT write loads bits 3:0 into the counter, unless a clock event occurs in the same cycle. In that case the counter takes the increment and the written count is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 2 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | 8 | Read data, combinational |
| tmr_match | input | 1 | Timer compare-match pulse |
| gie | input | 1 | Global interrupt enable |
| sclk_pin | input | 1 | External serial clock, asynchronous |
| sdi_pin | input | 1 | Serial data in, asynchronous |
| sdo | output | 1 | Serial data out from the output latch |
| sclk_out | output | 1 | Software-toggled serial clock line |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two functions can fall in the same cycle: a counter overflow, and a write that clears the flag and reloads the counter. The bench sets the counter to 15 in timer mode. It then drives tmr_match and a STAT write of 0x80 on the same clock edge. It expects STAT to read back 0x80: the flag survives and the counter holds the wrapped value 0 rather than the written one. The vector walk under strobe clocking also reaches wraps from counts of 8, 14 and 15.

// File: rtl/sshift_unit.sv
module sshift_unit #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic [1:0] bus_raddr,
  output logic [7:0] bus_rdata,
  input  logic       tmr_match,
  input  logic       gie,
  input  logic       sclk_pin,
  input  logic       sdi_pin,
  output logic       sdo,
  output logic       sclk_out,
  output logic       irq
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam int SL = SYNC_STAGES - 1;

  logic [7:0] shreg;
  logic [3:0] cnt;
  logic       ovf, ie, copt, sclk_q, latch_q, eff_prev;
  logic [1:0] csel;
  logic [SL:0] ck_sync, di_sync;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_sync <= '0;
      di_sync <= '0;
    end else begin
      ck_sync <= {ck_sync[SL-1:0], sclk_pin};
      di_sync <= {di_sync[SL-1:0], sdi_pin};
    end

  wire ck_s    = ck_sync[SL];
  wire di_s    = di_sync[SL];
  wire wr_data = bus_we && bus_addr == A_DATA;
  wire wr_stat = bus_we && bus_addr == A_STAT;
  wire wr_ctrl = bus_we && bus_addr == A_CTRL;

  wire eff       = copt ? sclk_q : ck_s;
  wire ext_edge  = csel[1] && (eff != eff_prev);
  wire samp_edge = ext_edge && (eff ^ csel[0]);
  wire lat_evt   = ext_edge && !(eff ^ csel[0]);
  wire strobe    = wr_ctrl && bus_wdata[1] && csel == 2'b00;
  wire tick      = csel == 2'b01 && tmr_match;
  wire shift_evt = strobe || tick || samp_edge;
  wire cnt_evt   = strobe || tick || ext_edge;
  wire wrap      = cnt_evt && cnt == 4'hF;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg    <= '0;
      cnt      <= '0;
      ovf      <= 1'b0;
      ie       <= 1'b0;
      csel     <= 2'b00;
      copt     <= 1'b0;
      sclk_q   <= 1'b0;
      latch_q  <= 1'b0;
      eff_prev <= 1'b0;
    end else begin
      eff_prev <= eff;
      if (wr_data)        shreg <= bus_wdata;
      else if (shift_evt) shreg <= {shreg[6:0], di_s};
      if (cnt_evt)        cnt <= cnt + 4'd1;
      else if (wr_stat)   cnt <= bus_wdata[3:0];
      if (wrap)                           ovf <= 1'b1;
      else if (wr_stat && bus_wdata[7])   ovf <= 1'b0;
      if (wr_ctrl) begin
        ie   <= bus_wdata[7];
        csel <= bus_wdata[3:2];
        copt <= bus_wdata[1];
        if (bus_wdata[0]) sclk_q <= ~sclk_q;
      end
      if (!csel[1] || lat_evt) latch_q <= shreg[7];
    end

  assign sdo      = csel[1] ? latch_q : shreg[7];
  assign sclk_out = sclk_q;
  assign irq      = ovf && ie && gie;

  always_comb
    case (bus_raddr)
      A_DATA:  bus_rdata = shreg;
      A_STAT:  bus_rdata = {ovf, 3'b000, cnt};
      A_CTRL:  bus_rdata = {ie, 3'b000, csel, copt, 1'b0};
      default: bus_rdata = 8'h00;
    endcase
endmodule

module sshift_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       tmr_match,
  input logic       gie,
  input logic       irq,
  input logic       sdo,
  input logic [3:0] cnt,
  input logic       ovf,
  input logic [1:0] csel,
  input logic       cnt_evt,
  input logic       lat_evt
);
  wire stat_wr = bus_we && bus_addr == 2'd1;
  wire ctrl_wr = bus_we && bus_addr == 2'd2;

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie); // R9
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 4'hF && cnt_evt) |=> (ovf && cnt == 4'h0)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(stat_wr && bus_wdata[7])) |=> ovf); // R8
  AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (csel == 2'b01 && !tmr_match && !stat_wr) |=> $stable(cnt)); // R3
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (csel[1] && !lat_evt && !ctrl_wr) |=> $stable(sdo)); // R5
endmodule

bind sshift_unit sshift_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tmr_match(tmr_match), .gie(gie), .irq(irq),
  .sdo(sdo), .cnt(cnt), .ovf(ovf), .csel(csel), .cnt_evt(cnt_evt),
  .lat_evt(lat_evt)
);

// File: tb/sshift_unit_tb.sv
`timescale 1ns/1ps
module sshift_unit_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, bus_we = 1'b0, tmr_match = 1'b0, gie = 1'b0;
  logic       sclk_pin = 1'b0, sdi_pin = 1'b0;
  logic [1:0] bus_addr = '0, bus_raddr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, r;
  logic       sdo, sclk_out, irq;
  int n_chk = 0, n_bad = 0;

  sshift_unit u_dut (.*);

  // {data, sdi, start count, strobes, expected data, expected count, expected flag}
  localparam logic [29:0] VEC [8] = '{
    {8'hA5, 1'b0, 4'd0,  4'd1, 8'h4A, 4'd1,  1'b0},
    {8'hA5, 1'b1, 4'd0,  4'd1, 8'h4B, 4'd1,  1'b0},
    {8'h81, 1'b0, 4'd14, 4'd2, 8'h04, 4'd0,  1'b1},
    {8'h0F, 1'b1, 4'd3,  4'd4, 8'hFF, 4'd7,  1'b0},
    {8'h3C, 1'b0, 4'd15, 4'd1, 8'h78, 4'd0,  1'b1},
    {8'hFF, 1'b0, 4'd8,  4'd8, 8'h00, 4'd0,  1'b1},
    {8'h12, 1'b1, 4'd10, 4'd3, 8'h97, 4'd13, 1'b0},
    {8'hC3, 1'b0, 4'd12, 4'd3, 8'h18, 4'd15, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_raddr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pin(input logic v);
    sclk_pin = v;
    idle(5);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    rd(0, r); check("R1 DATA", r, 8'h00);
    rd(1, r); check("R1 STAT", r, 8'h00);
    rd(2, r); check("R1 CTRL", r, 8'h00);
    check("R1 pins", {5'b0, irq, sdo, sclk_out}, 8'h00);

    for (int i = 0; i < 8; i++) begin
      logic [29:0] v;
      v = VEC[i];
      wr(1, {4'b1000, v[20:17]});
      wr(0, v[29:22]);
      sdi_pin = v[21];
      idle(4);
      for (int k = 0; k < int'(v[16:13]); k++) wr(2, 8'h02);
      rd(0, r); check("R2 shifted data", r, v[12:5]);
      rd(1, r); check("R7 flag/count", r, {v[0], 3'b000, v[4:1]});
      check("R5 transparent sdo", {7'b0, sdo}, {7'b0, v[12]});
    end

    // rising-edge sampling from the pin
    wr(2, 8'h08);
    wr(1, 8'h80);
    sdi_pin = 1'b1;
    wr(0, 8'hC0);
    check("R5 latch holds over write", {7'b0, sdo}, 8'h00);
    pin(1'b1);
    rd(0, r); check("R4 rising sample", r, 8'h81);
    check("R5 no update on sample edge", {7'b0, sdo}, 8'h00);
    pin(1'b0);
    rd(0, r); check("R4 falling no shift", r, 8'h81);
    rd(1, r); check("R4 both edges counted", r, 8'h02);
    check("R5 update on opposite edge", {7'b0, sdo}, 8'h01);

    // falling-edge sampling
    wr(2, 8'h0C);
    wr(1, 8'h80);
    sdi_pin = 1'b0;
    wr(0, 8'h40);
    pin(1'b1);
    rd(0, r); check("R4 rising ignored for shift", r, 8'h40);
    check("R5 latch on rising", {7'b0, sdo}, 8'h00);
    pin(1'b0);
    rd(0, r); check("R4 falling sample", r, 8'h80);
    check("R5 held after sample", {7'b0, sdo}, 8'h00);
    pin(1'b1);
    check("R5 latch takes msb", {7'b0, sdo}, 8'h01);
    rd(1, r); check("R4 count three edges", r, 8'h03);
    pin(1'b0);

    // software-toggled serial clock
    wr(2, 8'h0A);
    wr(1, 8'h80);
    wr(0, 8'h55);
    sdi_pin = 1'b1;
    idle(4);
    wr(2, 8'h0B);
    idle(3);
    check("R6 sclk_out toggled", {7'b0, sclk_out}, 8'h01);
    rd(0, r); check("R6 toggle rising samples", r, 8'hAB);
    pin(1'b1);
    pin(1'b0);
    rd(0, r); check("R6 pin ignored data", r, 8'hAB);
    rd(1, r); check("R6 pin ignored count", r, 8'h01);
    wr(2, 8'h0B);
    idle(3);
    check("R6 sclk_out back low", {7'b0, sclk_out}, 8'h00);
    check("R6 latch on toggle fall", {7'b0, sdo}, 8'h01);
    rd(1, r); check("R6 count two", r, 8'h02);

    // timer match clocking
    wr(2, 8'h04);
    wr(1, 8'h80);
    wr(0, 8'h00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); tmr_match = 1'b1;
      @(negedge clk); tmr_match = 1'b0;
    end
    rd(0, r); check("R3 timer shifts", r, 8'h07);
    rd(1, r); check("R3 timer counts", r, 8'h03);
    wr(2, 8'h06);
    rd(0, r); check("R3 strobe ignored data", r, 8'h07);
    rd(1, r); check("R3 strobe ignored count", r, 8'h03);
    wr(2, 8'h04);

    // overflow colliding with a clearing write
    wr(1, 8'h0F);
    @(negedge clk);
    tmr_match = 1'b1; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h80;
    @(negedge clk);
    tmr_match = 1'b0; bus_we = 1'b0;
    rd(1, r); check("R8 R10 overflow beats clear", r, 8'h80);

    // interrupt gating
    gie = 1'b1;
    idle(1);
    check("R9 irq off without enable", {7'b0, irq}, 8'h00);
    wr(2, 8'h84);
    check("R9 pending flag raises irq", {7'b0, irq}, 8'h01);
    gie = 1'b0;
    #1;
    check("R9 global gate", {7'b0, irq}, 8'h00);
    gie = 1'b1;
    wr(1, 8'h00);
    rd(1, r); check("R8 zero write keeps flag", r, 8'h80);
    check("R9 irq still up", {7'b0, irq}, 8'h01);
    wr(1, 8'h80);
    rd(1, r); check("R8 one clears flag", r, 8'h00);
    check("R9 irq drops", {7'b0, irq}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule